// File: doc/BRIEF.md
# FIFO Fill-Threshold Interrupt Generator

This block raises the receive-data-ready and transmit-empty interrupt conditions for a serial port that has 128-byte receive and transmit FIFOs. The FIFO logic gives it the current fill count of each FIFO. The block compares each count with a threshold and drives one level-sensitive flag per direction. There is one flag for receive and one for transmit.

Each threshold comes from one of four tables. Three tables are fixed and have four entries each, chosen by a 2-bit level code per direction. The fourth table uses byte values that are written through one trigger register. A direction bit steers each write of that register to either the receive value or the transmit value. The table-select field and the trigger register are reachable only while the line-setup register holds a special unlock value. The level codes are reachable only in the normal register map.

Every threshold is held in a register, so a change of table, code or user value takes effect one clock after the write. Both interrupt flags are combinational functions of the fill counts and the registered thresholds.

Top module: `trig_level_irq`

## Requirements
- R1: After synchronous reset, the fixed table with levels 1, 4, 8 and 14 is selected. Both level codes are 00, and both user values are 1. As a result, rx_irq is set for rx_count >= 1 and tx_irq is set for tx_count <= 1.
- R2: Table select 00 maps each 2-bit level code as follows: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. The receive code sits in bits 7:6 and the transmit code in bits 5:4 of the FIFO-control register at address 2.
- R3: Table select 01 maps level codes 00, 01, 10 and 11 to 8, 16, 24 and 28 bytes.
- R4: Table select 10 maps level codes 00, 01, 10 and 11 to 8, 16, 56 and 60 bytes.
- R5: Table select 11 uses the stored user values as the receive and transmit thresholds. In this table, both level codes have no effect.
- R6: The feature register sits at address 1. Its bits 5:4 hold the table select and its bit 7 holds the direction. A write to the trigger register at address 0 stores the receive user value when the direction bit is 0. It stores the transmit user value when the direction bit is 1. The other user value is left unchanged.
- R7: The line-setup register sits at address 3. Writes to addresses 0 and 1 take effect only while it holds 0xBF. Writes to address 2 take effect only while it holds any other value, for example 0x03.
- R8: rx_irq is high exactly when rx_count >= the receive threshold. It falls as soon as the count drops below the threshold, and it rises again when the count refills to the threshold.
- R9: tx_irq is high exactly when tx_count <= the transmit threshold. For example, a threshold of 8 fires with 8 bytes left.
- R10: A trigger value of 0 is stored as 1. A trigger value above 128 is stored as 128.
- R11: A register write changes the thresholds, and therefore the flags, from the clock edge that accepts it. Before that edge, the flags follow the old thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rx_count | input | 8 | Receive FIFO fill count, 0 to 128 |
| tx_count | input | 8 | Transmit FIFO fill count, 0 to 128 |
| rx_irq | output | 1 | Receive fill-threshold flag |
| tx_irq | output | 1 | Transmit drain-threshold flag |

## Verification
The block's internal state is only the stored registers: table select, direction bit, level codes, two user values and the unlock value. A wrong bit in any of these changes a threshold, so it shows at the flags within one clock of the write that caused it. The error is visible only when the fill count sits on the boundary of the threshold. For this reason, the bench probes every threshold at the count where the flag should change and at the count one step beside it. A wrong gate decision or a wrong steering decision shows the same way, as a boundary that has moved or that did not move when it should have.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int FIFO_DEPTH_DEF = 128;
    localparam logic [7:0] UNLOCK_VAL = 8'hBF;

    localparam logic [2:0] ADDR_TRIG = 3'd0;
    localparam logic [2:0] ADDR_FEAT = 3'd1;
    localparam logic [2:0] ADDR_FCTL = 3'd2;
    localparam logic [2:0] ADDR_LINE = 3'd3;

    typedef enum logic [1:0] {
        TBL_SMALL = 2'b00,
        TBL_MID   = 2'b01,
        TBL_WIDE  = 2'b10,
        TBL_USER  = 2'b11
    } trig_tbl_e;

    typedef struct packed {
        logic      dir_tx;
        trig_tbl_e tbl;
    } feat_s;

    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
    } lvl_s;

    // Fixed-table lookup: level in bytes for a table and a 2-bit code.
    function automatic logic [7:0] fixed_level(trig_tbl_e t, logic [1:0] c);
        logic [7:0] v;
        unique case (t)
            TBL_SMALL: begin
                unique case (c)
                    2'b00: v = 8'd1;
                    2'b01: v = 8'd4;
                    2'b10: v = 8'd8;
                    default: v = 8'd14;
                endcase
            end
            TBL_MID: begin
                unique case (c)
                    2'b00: v = 8'd8;
                    2'b01: v = 8'd16;
                    2'b10: v = 8'd24;
                    default: v = 8'd28;
                endcase
            end
            TBL_WIDE: begin
                unique case (c)
                    2'b00: v = 8'd8;
                    2'b01: v = 8'd16;
                    2'b10: v = 8'd56;
                    default: v = 8'd60;
                endcase
            end
            default: v = 8'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/trig_regfile.sv
module trig_regfile
    import trig_pkg::*;
#(
    parameter int DEPTH  = FIFO_DEPTH_DEF,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output feat_s             feat,
    output lvl_s              lvl,
    output logic [CNT_W-1:0]  user_rx,
    output logic [CNT_W-1:0]  user_tx
);
    localparam logic [CNT_W-1:0] USER_MIN = CNT_W'(1);
    localparam logic [CNT_W-1:0] USER_MAX = CNT_W'(DEPTH);

    logic [DATA_W-1:0] line_q;
    feat_s             feat_q;
    lvl_s              lvl_q;
    logic [CNT_W-1:0]  user_rx_q, user_tx_q;
    logic              unlocked;
    logic              we_line, we_fctl, we_feat, we_trig;
    logic [CNT_W-1:0]  trig_sat;

    assign unlocked = (line_q == DATA_W'(UNLOCK_VAL));
    assign we_line  = wr_en && (wr_addr == ADDR_W'(ADDR_LINE));
    assign we_fctl  = wr_en && (wr_addr == ADDR_W'(ADDR_FCTL)) && !unlocked;
    assign we_feat  = wr_en && (wr_addr == ADDR_W'(ADDR_FEAT)) &&  unlocked;
    assign we_trig  = wr_en && (wr_addr == ADDR_W'(ADDR_TRIG)) &&  unlocked;

    // Clamp the user byte into 1..DEPTH.
    always_comb begin
        if (wr_data == '0)
            trig_sat = USER_MIN;
        else if (int'(wr_data) > DEPTH)
            trig_sat = USER_MAX;
        else
            trig_sat = CNT_W'(wr_data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q    <= '0;
            feat_q    <= '{dir_tx: 1'b0, tbl: TBL_SMALL};
            lvl_q     <= '{rx_code: 2'b00, tx_code: 2'b00};
            user_rx_q <= USER_MIN;
            user_tx_q <= USER_MIN;
        end else begin
            if (we_line)
                line_q <= wr_data;
            if (we_fctl)
                lvl_q <= '{rx_code: wr_data[7:6], tx_code: wr_data[5:4]};
            if (we_feat)
                feat_q <= '{dir_tx: wr_data[7], tbl: trig_tbl_e'(wr_data[5:4])};
            if (we_trig) begin
                if (feat_q.dir_tx)
                    user_tx_q <= trig_sat;
                else
                    user_rx_q <= trig_sat;
            end
        end
    end

    assign feat    = feat_q;
    assign lvl     = lvl_q;
    assign user_rx = user_rx_q;
    assign user_tx = user_tx_q;

    assert_gate_feat_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(ADDR_FEAT) && line_q != DATA_W'(UNLOCK_VAL))
        |=> $stable(feat_q));

    assert_gate_fctl_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(ADDR_FCTL) && line_q == DATA_W'(UNLOCK_VAL))
        |=> $stable(lvl_q));

    assert_steer_rx_R6: assert property (@(posedge clk) disable iff (rst)
        (we_trig && !feat_q.dir_tx) |=> $stable(user_tx_q));

    assert_steer_tx_R6: assert property (@(posedge clk) disable iff (rst)
        (we_trig && feat_q.dir_tx) |=> $stable(user_rx_q));

    assert_user_range_R10: assert property (@(posedge clk) disable iff (rst)
        (user_rx_q >= USER_MIN && user_rx_q <= USER_MAX &&
         user_tx_q >= USER_MIN && user_tx_q <= USER_MAX));

endmodule

// File: rtl/trig_resolve.sv
module trig_resolve
    import trig_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH_DEF,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  feat_s            feat,
    input  lvl_s             lvl,
    input  logic [CNT_W-1:0] user_rx,
    input  logic [CNT_W-1:0] user_tx,
    output logic [CNT_W-1:0] thr_rx,
    output logic [CNT_W-1:0] thr_tx
);
    localparam int NDIR = 2;

    logic [1:0]       code_a [NDIR];
    logic [CNT_W-1:0] user_a [NDIR];
    logic [CNT_W-1:0] thr_a  [NDIR];

    assign code_a[0] = lvl.rx_code;
    assign code_a[1] = lvl.tx_code;
    assign user_a[0] = user_rx;
    assign user_a[1] = user_tx;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        always_comb begin
            if (feat.tbl == TBL_USER)
                thr_a[d] = user_a[d];
            else
                thr_a[d] = CNT_W'(fixed_level(feat.tbl, code_a[d]));
        end

        assert_thr_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
            thr_a[d] != '0);

        assert_user_ignores_code_R5: assert property (@(posedge clk) disable iff (rst)
            (feat.tbl == TBL_USER && $stable(feat) && $stable(user_a[d]))
            |-> $stable(thr_a[d]));
    end

    assign thr_rx = thr_a[0];
    assign thr_tx = thr_a[1];

endmodule

// File: rtl/trig_compare.sv
module trig_compare #(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter bit DRAIN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] thr,
    output logic             irq
);
    if (DRAIN) begin : g_drain
        assign irq = (count <= thr);

        assert_empty_fires_R9: assert property (@(posedge clk) disable iff (rst)
            (count == '0) |-> irq);
    end else begin : g_fill
        assign irq = (count >= thr);

        assert_full_fires_R8: assert property (@(posedge clk) disable iff (rst)
            (count >= CNT_W'(DEPTH)) |-> irq);

        assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
            (!irq && $stable(thr) && count > $past(count) && count >= thr) |-> irq);
    end

endmodule

// File: rtl/trig_level_irq.sv
module trig_level_irq
    import trig_pkg::*;
#(
    parameter int DEPTH  = FIFO_DEPTH_DEF,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    output logic              rx_irq,
    output logic              tx_irq
);
    feat_s            feat;
    lvl_s             lvl;
    logic [CNT_W-1:0] user_rx, user_tx;
    logic [CNT_W-1:0] thr_rx, thr_tx;

    trig_regfile #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .feat    (feat),
        .lvl     (lvl),
        .user_rx (user_rx),
        .user_tx (user_tx)
    );

    trig_resolve #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_resolve (
        .clk     (clk),
        .rst     (rst),
        .feat    (feat),
        .lvl     (lvl),
        .user_rx (user_rx),
        .user_tx (user_tx),
        .thr_rx  (thr_rx),
        .thr_tx  (thr_tx)
    );

    trig_compare #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DRAIN(1'b0)) u_cmp_rx (
        .clk   (clk),
        .rst   (rst),
        .count (rx_count),
        .thr   (thr_rx),
        .irq   (rx_irq)
    );

    trig_compare #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DRAIN(1'b1)) u_cmp_tx (
        .clk   (clk),
        .rst   (rst),
        .count (tx_count),
        .thr   (thr_tx),
        .irq   (tx_irq)
    );

    assert_reset_table_R1: assert property (@(posedge clk)
        rst |=> (feat.tbl == TBL_SMALL && lvl.rx_code == 2'b00 && lvl.tx_code == 2'b00));

    assert_no_write_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(thr_rx) && $stable(thr_tx)));

endmodule

// File: tb/test_trig_level_irq.sv
module test_trig_level_irq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rx_count = '0;
    logic [7:0] tx_count = '0;
    logic       rx_irq, tx_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trig_level_irq i_trig_level_irq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rx_count(rx_count), .tx_count(tx_count), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    typedef struct packed {
        logic [1:0] tbl;
        logic [1:0] rxc;
        logic [1:0] txc;
        logic [7:0] rxn;
        logic [7:0] txn;
        logic       erx;
        logic       etx;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 2'd0, 8'd1,  8'd2,  1'b1, 1'b0},
        '{2'd0, 2'd3, 2'd2, 8'd13, 8'd9,  1'b0, 1'b0},
        '{2'd0, 2'd3, 2'd2, 8'd14, 8'd8,  1'b1, 1'b1},
        '{2'd0, 2'd1, 2'd1, 8'd3,  8'd4,  1'b0, 1'b1},
        '{2'd1, 2'd2, 2'd0, 8'd24, 8'd8,  1'b1, 1'b1},
        '{2'd1, 2'd3, 2'd1, 8'd27, 8'd17, 1'b0, 1'b0},
        '{2'd1, 2'd0, 2'd3, 8'd8,  8'd28, 1'b1, 1'b1},
        '{2'd2, 2'd2, 2'd2, 8'd56, 8'd57, 1'b1, 1'b0},
        '{2'd2, 2'd3, 2'd3, 8'd59, 8'd60, 1'b0, 1'b1},
        '{2'd2, 2'd1, 2'd2, 8'd16, 8'd0,  1'b1, 1'b1}
    };

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic setc(input logic [7:0] r, input logic [7:0] t);
        @(negedge clk);
        rx_count = r; tx_count = t;
        #1;
    endtask

    function automatic string tbl_req(input logic [1:0] t);
        case (t)
            2'd0: return "R2";
            2'd1: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state: rx threshold 1, tx threshold 1
        setc(8'd0, 8'd2);
        chk(rx_irq, 1'b0, "R1 rx at 0");
        chk(tx_irq, 1'b0, "R1 tx at 2");
        setc(8'd1, 8'd1);
        chk(rx_irq, 1'b1, "R1 rx at 1");
        chk(tx_irq, 1'b1, "R1 tx at 1");

        // Vector walk over fixed tables (R2 R3 R4, flags per R8 R9)
        for (int i = 0; i < NV; i++) begin
            wr(3'd3, 8'hBF);
            wr(3'd1, {2'b00, VECS[i].tbl, 4'h0});
            wr(3'd3, 8'h03);
            wr(3'd2, {VECS[i].rxc, VECS[i].txc, 4'h0});
            setc(VECS[i].rxn, VECS[i].txn);
            chk(rx_irq, VECS[i].erx, {tbl_req(VECS[i].tbl), " R8 rx vector"});
            chk(tx_irq, VECS[i].etx, {tbl_req(VECS[i].tbl), " R9 tx vector"});
        end

        // R7: feature write while locked has no effect; table stays fixed
        wr(3'd3, 8'hBF); wr(3'd1, 8'h00); wr(3'd3, 8'h03);
        wr(3'd2, 8'hC0);                 // rx code 11 -> 14
        wr(3'd1, 8'h30);                 // locked: ignored
        setc(8'd13, 8'd50);
        chk(rx_irq, 1'b0, "R7 locked feature write, rx 13");
        setc(8'd14, 8'd50);
        chk(rx_irq, 1'b1, "R7 locked feature write, rx 14");
        // R7: FIFO-control write while unlocked has no effect
        wr(3'd3, 8'hBF); wr(3'd2, 8'h00); wr(3'd3, 8'h03);
        setc(8'd13, 8'd50);
        chk(rx_irq, 1'b0, "R7 unlocked fifo-control write");

        // R5/R6: user table, steered trigger writes
        wr(3'd3, 8'hBF);
        wr(3'd1, 8'h30); wr(3'd0, 8'h60);   // rx 96
        wr(3'd1, 8'hB0); wr(3'd0, 8'h08);   // tx 8
        wr(3'd3, 8'h03);
        setc(8'd95, 8'd9);
        chk(rx_irq, 1'b0, "R6 rx 95 vs 96");
        chk(tx_irq, 1'b0, "R6 tx 9 vs 8");
        setc(8'd96, 8'd8);
        chk(rx_irq, 1'b1, "R6 rx 96 vs 96");
        chk(tx_irq, 1'b1, "R9 tx 8 vs 8");
        wr(3'd2, 8'h00);                     // codes ignored in user table
        setc(8'd95, 8'd9);
        chk(rx_irq, 1'b0, "R5 code ignored rx");
        chk(tx_irq, 1'b0, "R5 code ignored tx");

        // R8 re-arm sequence at threshold 96
        setc(8'd96, 8'd50); chk(rx_irq, 1'b1, "R8 reach");
        setc(8'd95, 8'd50); chk(rx_irq, 1'b0, "R8 drain below");
        setc(8'd96, 8'd50); chk(rx_irq, 1'b1, "R8 refill");

        // R10 clamping
        wr(3'd3, 8'hBF); wr(3'd1, 8'h30); wr(3'd0, 8'h00);
        setc(8'd0, 8'd50); chk(rx_irq, 1'b0, "R10 zero->1 rx 0");
        setc(8'd1, 8'd50); chk(rx_irq, 1'b1, "R10 zero->1 rx 1");
        wr(3'd0, 8'd200);
        setc(8'd127, 8'd50); chk(rx_irq, 1'b0, "R10 clamp rx 127");
        setc(8'd128, 8'd50); chk(rx_irq, 1'b1, "R10 clamp rx 128");
        wr(3'd1, 8'hB0); wr(3'd0, 8'h00);
        setc(8'd128, 8'd2); chk(tx_irq, 1'b0, "R10 zero->1 tx 2");
        setc(8'd128, 8'd1); chk(tx_irq, 1'b1, "R10 zero->1 tx 1");
        chk(rx_irq, 1'b1, "R6 rx kept at 128");

        // R11: change visible only after the accepting edge
        wr(3'd1, 8'h00); wr(3'd3, 8'h03); wr(3'd2, 8'h00);
        setc(8'd4, 8'd50);
        chk(rx_irq, 1'b1, "R11 before write");
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'hC0;
        #1 chk(rx_irq, 1'b1, "R11 pending write, old threshold");
        @(posedge clk);
        #1 wr_en = 1'b0;
        chk(rx_irq, 1'b0, "R11 after edge, threshold 14");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule